// File: doc/BRIEF.md
# DMA Data Width Adapter

This block sits between the read phase and the write phase of a DMA transfer. It takes a data item read at the source size of 8, 16 or 32 bits and produces the item to be written at the destination size. A narrow source is zero-extended and a wide source keeps only its least significant part. The result goes out on a 32-bit write bus, together with a size code. Every byte lane that the destination size leaves unused carries a copy of the item. A slave that ignores the size code and always stores a full word still receives the intended value.

The adapter has one register stage. Inputs presented at one rising edge appear on the write outputs after that edge, in time for the write issue. The low bits of the destination address are accepted but they do not select lanes, because every lane carries the data. Address generation and the bus handshake belong to the surrounding engine.

Top module: `wadp_width_adapter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `wr_data` = 0 and `wr_size` = 2'b00. This holds whatever the data inputs are.
- R2: The outputs change only at a rising edge. They reflect the inputs sampled at that edge, which gives one cycle of latency.
- R3: Size codes are 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. When source and destination codes are equal, the item passes through unchanged: byte in lanes [7:0], halfword in [15:0], word in [31:0].
- R4: When the source is narrower than the destination, the item is zero-extended. Byte 0xB0 written as a halfword gives 0x00B0 in [15:0]. Written as a word, it gives 0x000000B0.
- R5: When the source is wider than the destination, only the low part is written. Word 0xB3B2B1B0 written as a byte gives 0xB0, and written as a halfword gives 0xB1B0.
- R6: For a byte destination, all four byte lanes of `wr_data` carry the byte, so 0xAB drives 0xABABABAB.
- R7: For a halfword destination, both 16-bit halves of `wr_data` carry the halfword, so 0xABCD drives 0xABCDABCD.
- R8: `wr_size` equals the destination size code sampled at the previous edge.
- R9: `dst_addr_lo` has no effect on `wr_data` or `wr_size`.
- R10: Code 2'b11 is reserved. If it appears on either size input, `wr_data` becomes 0, while `wr_size` still follows R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_data | input | 32 | Data returned by the read phase, right-aligned |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| dst_addr_lo | input | 2 | Low destination address bits, not used for lane selection |
| wr_data | output | 32 | Write bus data with lane duplication |
| wr_size | output | 2 | Write size code |

## Verification
The only state in this block is the output register. A wrong internal value appears on `wr_data` or `wr_size` in the cycle right after the edge that captured it, and it is gone one edge later. A sizing fault shows up as nonzero high bits after a narrow source, or as stray bits surviving a truncation. A duplication fault shows up as byte lanes that disagree under a byte or halfword size. Each item is therefore compared at the first sample point after its capture edge, against a model that builds the expected lanes from sizes alone.

// File: rtl/wadp_pkg.sv
// Package: shared size codes and widths for the data width adapter.
// Assumes a 32-bit write bus made of 8-bit lanes.
package wadp_pkg;
    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = BUS_W / BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // Mask keeping the bits that an item of the given size occupies.
    function automatic logic [BUS_W-1:0] size_mask(input size_e sz);
        case (sz)
            SZ_BYTE: size_mask = {{(BUS_W-8){1'b0}}, 8'hFF};
            SZ_HALF: size_mask = {{(BUS_W-16){1'b0}}, 16'hFFFF};
            SZ_WORD: size_mask = {BUS_W{1'b1}};
            default: size_mask = '0;
        endcase
    endfunction
endpackage

// File: rtl/wadp_resize.sv
// Module: wadp_resize
// Zero-extends or truncates a right-aligned read item to the destination size.
// Assumes the item is right-aligned in rd_data. A reserved code yields zero.
module wadp_resize
    import wadp_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic [W-1:0] rd_data,
    input  size_e        src_sz,
    input  size_e        dst_sz,
    output logic [W-1:0] item,
    output logic         rsvd
);
    logic [W-1:0] src_keep;
    logic [W-1:0] dst_keep;

    // Flag any reserved size code on either side.
    always_comb begin
        rsvd = (src_sz == SZ_RSVD) || (dst_sz == SZ_RSVD);
    end

    // Masks: the source mask zero-extends, the destination mask truncates.
    always_comb begin
        src_keep = size_mask(src_sz);
        dst_keep = size_mask(dst_sz);
    end

    // Apply both masks, and force zero on a reserved code.
    always_comb begin
        if (rsvd) item = '0;
        else      item = rd_data & src_keep & dst_keep;
    end
endmodule

// File: rtl/wadp_replicate.sv
// Module: wadp_replicate
// Copies a sized item into every byte lane of the write bus.
// Assumes the item is already masked to the destination size.
module wadp_replicate
    import wadp_pkg::*;
#(
    parameter int NL = LANES,
    parameter int BW = BYTE_W
) (
    input  logic [NL*BW-1:0] item,
    input  size_e            dst_sz,
    output logic [NL*BW-1:0] bus
);
    localparam int HALF_LANES = 2;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam int HIDX = g % HALF_LANES;
        // Select the source byte for lane g according to the destination size.
        always_comb begin
            case (dst_sz)
                SZ_BYTE: bus[g*BW +: BW] = item[0 +: BW];
                SZ_HALF: bus[g*BW +: BW] = item[HIDX*BW +: BW];
                default: bus[g*BW +: BW] = item[g*BW +: BW];
            endcase
        end
    end
endmodule

// File: rtl/wadp_out_reg.sv
// Module: wadp_out_reg
// Holds the write data and size for one cycle, between the read capture and the write issue.
// Assumes a synchronous, active-low reset.
module wadp_out_reg #(
    parameter int W  = 32,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d_data,
    input  logic [SW-1:0] d_size,
    output logic [W-1:0]  q_data,
    output logic [SW-1:0] q_size
);
    // Capture every cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_size <= '0;
        end else begin
            q_data <= d_data;
            q_size <= d_size;
        end
    end
endmodule

// File: rtl/wadp_width_adapter.sv
// Module: wadp_width_adapter (top)
// Resizes one read item to the destination size, duplicates it across lanes,
// and registers the result for the write phase.
// Assumes inputs are stable around the rising edge. Address bits do not select lanes.
module wadp_width_adapter
    import wadp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] rd_data,
    input  logic [1:0]       src_size,
    input  logic [1:0]       dst_size,
    input  logic [1:0]       dst_addr_lo,
    output logic [BUS_W-1:0] wr_data,
    output logic [1:0]       wr_size
);
    size_e            src_e;
    size_e            dst_e;
    logic [BUS_W-1:0] item;
    logic [BUS_W-1:0] bus;
    logic             rsvd;
    logic [1:0]       addr_unused;

    // Decode the raw size inputs into the shared type.
    always_comb begin
        src_e = size_e'(src_size);
        dst_e = size_e'(dst_size);
    end

    // The address is accepted but not used, because every lane gets the data.
    assign addr_unused = dst_addr_lo;

    wadp_resize #(.W(BUS_W)) resize_i (
        .rd_data (rd_data),
        .src_sz  (src_e),
        .dst_sz  (dst_e),
        .item    (item),
        .rsvd    (rsvd)
    );

    wadp_replicate #(.NL(LANES), .BW(BYTE_W)) repl_i (
        .item   (item),
        .dst_sz (dst_e),
        .bus    (bus)
    );

    wadp_out_reg #(.W(BUS_W), .SW(2)) oreg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_data (bus),
        .d_size (dst_size),
        .q_data (wr_data),
        .q_size (wr_size)
    );

    // R8
    size_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> wr_size == $past(dst_size));

    // R6
    byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_size == 2'b00 |-> (wr_data[31:24] == wr_data[7:0]) &&
                             (wr_data[23:16] == wr_data[7:0]) &&
                             (wr_data[15:8]  == wr_data[7:0]));

    // R7
    half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_size == 2'b01 |-> wr_data[31:16] == wr_data[15:0]);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(src_size) == 2'b11 || $past(dst_size) == 2'b11))
        |-> wr_data == '0);

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_size) == 2'b00 &&
         ($past(dst_size) == 2'b01 || $past(dst_size) == 2'b10))
        |-> wr_data[15:8] == 8'h00);

    // R3 R5
    low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_size) != 2'b11 && $past(dst_size) != 2'b11)
        |-> wr_data[7:0] == $past(rd_data[7:0]));
endmodule

// File: tb/wadp_width_adapter_tb.sv
module wadp_width_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] rd_data;
    logic [1:0]  src_size;
    logic [1:0]  dst_size;
    logic [1:0]  dst_addr_lo;
    logic [31:0] wr_data;
    logic [1:0]  wr_size;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wadp_width_adapter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_data     (rd_data),
        .src_size    (src_size),
        .dst_size    (dst_size),
        .dst_addr_lo (dst_addr_lo),
        .wr_data     (wr_data),
        .wr_size     (wr_size)
    );

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    // Expected write data, built from the requirements.
    function automatic logic [31:0] model(input logic [31:0] d,
                                          input logic [1:0] s, input logic [1:0] t);
        logic [31:0] r;
        int keep;
        int unit;
        if (s == 2'b11 || t == 2'b11) return 32'h0;
        keep = (nbytes(s) < nbytes(t)) ? nbytes(s) : nbytes(t);
        unit = nbytes(t);
        r = '0;
        for (int i = 0; i < 4; i++) begin
            int k;
            k = i % unit;
            if (k < keep) r[i*8 +: 8] = d[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, then check at the next falling edge after one capture.
    task automatic apply(input string tag, input logic [31:0] d,
                         input logic [1:0] s, input logic [1:0] t, input logic [1:0] a);
        rd_data = d; src_size = s; dst_size = t; dst_addr_lo = a;
        @(negedge clk);
        chk({tag, " data"}, wr_data, model(d, s, t));
        chk({"R8 ", tag, " size"}, {30'h0, wr_size}, {30'h0, t});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] save_d;
        logic [1:0]  save_s;
        void'($urandom(32'd4242));
        rst_n = 1'b0; rd_data = 32'hDEADBEEF; src_size = 2'b10; dst_size = 2'b01; dst_addr_lo = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1 reset data", wr_data, 32'h0);
        chk("R1 reset size", {30'h0, wr_size}, 32'h0);
        rst_n = 1'b1;

        apply("R3 byte-byte",  32'h000000AB, 2'b00, 2'b00, 2'b00);
        apply("R3 half-half",  32'h0000ABCD, 2'b01, 2'b01, 2'b00);
        apply("R3 word-word",  32'hB3B2B1B0, 2'b10, 2'b10, 2'b00);
        apply("R4 byte-half",  32'hFFFFFFB0, 2'b00, 2'b01, 2'b00);
        chk("R4 byte-half value", wr_data, 32'h00B000B0);
        apply("R4 byte-word",  32'h123456B0, 2'b00, 2'b10, 2'b00);
        chk("R4 byte-word value", wr_data, 32'h000000B0);
        apply("R4 half-word",  32'h9999B1B0, 2'b01, 2'b10, 2'b00);
        apply("R5 word-byte",  32'hB3B2B1B0, 2'b10, 2'b00, 2'b00);
        chk("R5 word-byte value", wr_data, 32'hB0B0B0B0);
        apply("R5 word-half",  32'hB3B2B1B0, 2'b10, 2'b01, 2'b00);
        chk("R5 word-half value", wr_data, 32'hB1B0B1B0);
        apply("R6 byte lanes", 32'h000000AB, 2'b00, 2'b00, 2'b01);
        chk("R6 byte lanes value", wr_data, 32'hABABABAB);
        apply("R7 half lanes", 32'h0000ABCD, 2'b01, 2'b01, 2'b10);
        chk("R7 half lanes value", wr_data, 32'hABCDABCD);
        apply("R10 rsvd src",  32'hFFFFFFFF, 2'b11, 2'b10, 2'b00);
        apply("R10 rsvd dst",  32'hFFFFFFFF, 2'b10, 2'b11, 2'b00);

        // R9: same item at every address offset.
        for (int a = 0; a < 4; a++) begin
            apply("R9 addr byte", 32'h5A5A12C3, 2'b10, 2'b00, a[1:0]);
            apply("R9 addr half", 32'h5A5A12C3, 2'b10, 2'b01, a[1:0]);
        end

        // R2: output holds until the next rising edge.
        save_d = wr_data; save_s = wr_size;
        rd_data = 32'h0F0F0F0F; src_size = 2'b10; dst_size = 2'b10;
        #2;
        chk("R2 hold data", wr_data, save_d);
        chk("R2 hold size", {30'h0, wr_size}, {30'h0, save_s});
        @(negedge clk);
        chk("R2 update", wr_data, 32'h0F0F0F0F);

        // Random mix covering R3 R4 R5 R6 R7 R10.
        for (int n = 0; n < 400; n++) begin
            logic [1:0] s;
            logic [1:0] t;
            s = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
            t = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
            apply("R3-mix random", $urandom, s, t, 2'($urandom));
        end

        // R1: reset in mid-run clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset data", wr_data, 32'h0);
        chk("R1 mid reset size", {30'h0, wr_size}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule